// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This unit settles control flow for a 64-bit register machine whose instructions each take one 8-byte slot. Each valid cycle it receives an opcode byte, the destination register value, the source register value, a 32-bit immediate, a signed 16-bit branch offset and the current program counter, counted in slots. One clock later it reports three things:

- whether a branch is taken;
- the program counter of the next instruction;
- flags for the surrounding control logic: illegal opcode, program exit, runtime service request, and the one double-length instruction.

The unit only recognises exit and service requests. Acting on them is left to the caller.

Conditional branches compare the destination value against either the source register or the sign-extended immediate. Opcode bit 3 selects which. The unit also checks the whole opcode byte against the instruction set. Any code outside that set is reported as illegal and never branches.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared: `out_valid`, `out_taken`, `out_illegal`, `out_exit`, `out_call`, `out_wide` are 0 and `out_next_pc` is 0.
- R2: Results appear exactly one clock after the inputs are sampled: `out_valid` equals the `in_valid` of the previous edge.
- R3: Branch class opcodes (low three bits 101) with high nibble 2, 3, 10, 11 compare dst against the operand unsigned, taken on greater, greater-or-equal, less and less-or-equal respectively.
- R4: High nibble 6, 7, 12, 13 of the branch class compare as two's complement signed values: greater, greater-or-equal, less and less-or-equal.
- R5: High nibble 1 is taken on equality, nibble 5 on inequality, and nibble 4 when the bitwise AND of dst and operand is nonzero.
- R6: In the branch class, opcode bit 3 = 0 makes the operand the 32-bit immediate sign-extended to 64 bits; bit 3 = 1 makes it the source register.
- R7: Opcode 0x05 is always taken. A taken branch yields next PC = PC + 1 + offset, with the 16-bit offset sign-extended and the sum wrapping modulo 2^32.
- R8: A legal instruction that is not a taken branch yields next PC = PC + 1, except opcode 0x18, which yields PC + 2 and raises `out_wide`.
- R9: Opcode 0x85 raises `out_call` and 0x95 raises `out_exit`. Neither is taken and both yield PC + 1. At most one of taken, illegal, exit, call and wide is set.
- R10: These codes are legal and all others are illegal:
  - 0x18;
  - the loads 0x61, 0x69, 0x71, 0x79;
  - the stores 0x63, 0x6b, 0x73, 0x7b;
  - low bits 111 with high nibble other than 13 or 15, where nibble 8 is legal only with bit 3 = 0;
  - low bits 100 with high nibble other than 15, where nibble 8 is legal only with bit 3 = 0;
  - low bits 101 with high nibble 0 to 13, where nibble 8 or 9 is legal only as 0x85 or 0x95, and nibble 0 is legal only as 0x05.

  An illegal code raises `out_illegal`, is not taken and yields PC + 1.
- R11: After an edge with `in_valid` low, `out_valid` and all flags are 0 and `out_next_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_dst | input | 64 | Destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate field |
| in_off | input | 16 | Signed branch offset in slots |
| in_pc | input | 32 | Current program counter in slots |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next program counter in slots |
| out_illegal | output | 1 | Opcode outside the instruction set |
| out_exit | output | 1 | Program exit requested |
| out_call | output | 1 | Runtime service requested |
| out_wide | output | 1 | Double-length instruction seen |

## Verification
The hardest case to reach from the ports is the boundary of the signed compares. There the sign-extended immediate and a register operand disagree in their top bits, so the unsigned and signed answers differ. Operands of all ones, only the sign bit set, and an immediate of 0xFFFFFFFF that must extend to all ones reach it. Every one of the 256 opcodes is swept against each of eight operand patterns. The patterns pair those values with offsets of -32768, +32767 and -3, and with PCs near zero and near the wrap point.

// File: rtl/br_pkg.sv
// Shared types for the branch resolution unit.
// Assumes opcode class in bits [2:0], source select in bit 3, operation in [7:4].
package br_pkg;

    typedef enum logic [3:0] {
        C_NEVER, C_ALWAYS, C_EQ, C_NE, C_GT, C_GE, C_LT, C_LE,
        C_SGT, C_SGE, C_SLT, C_SLE, C_SET
    } cond_t;

    typedef struct packed {
        cond_t cond;
        logic  use_reg;
        logic  legal;
        logic  wide;
        logic  is_exit;
        logic  is_call;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
// Opcode decoder: maps an opcode byte to a branch condition, the operand
// source and the legality/kind flags. Purely combinational.
// Assumes the caller qualifies the result with its own valid signal.
module br_decode
    import br_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);
    localparam logic [2:0] CLS_LDIMM = 3'h0;
    localparam logic [2:0] CLS_LOAD  = 3'h1;
    localparam logic [2:0] CLS_STORE = 3'h3;
    localparam logic [2:0] CLS_ALU32 = 3'h4;
    localparam logic [2:0] CLS_JUMP  = 3'h5;
    localparam logic [2:0] CLS_ALU64 = 3'h7;

    logic [2:0] cls;
    logic       sel_reg;
    logic [3:0] grp;

    assign cls     = opcode[2:0];
    assign sel_reg = opcode[3];
    assign grp     = opcode[7:4];

    // Branch-class operation nibble to condition code.
    function automatic cond_t jump_cond(input logic [3:0] g);
        case (g)
            4'h1:    return C_EQ;
            4'h2:    return C_GT;
            4'h3:    return C_GE;
            4'h4:    return C_SET;
            4'h5:    return C_NE;
            4'h6:    return C_SGT;
            4'h7:    return C_SGE;
            4'ha:    return C_LT;
            4'hb:    return C_LE;
            4'hc:    return C_SLT;
            4'hd:    return C_SLE;
            default: return C_NEVER;
        endcase
    endfunction

    // Classify the opcode byte.
    always_comb begin
        dec         = '0;
        dec.cond    = C_NEVER;
        dec.use_reg = sel_reg;
        case (cls)
            CLS_LDIMM: begin
                dec.legal = (opcode == 8'h18);
                dec.wide  = (opcode == 8'h18);
            end
            CLS_LOAD:  dec.legal = (grp inside {4'h6, 4'h7}) && (opcode[3:0] inside {4'h1, 4'h9});
            CLS_STORE: dec.legal = (grp inside {4'h6, 4'h7}) && (opcode[3:0] inside {4'h3, 4'hb});
            CLS_ALU32: dec.legal = (grp != 4'hf) && !(grp == 4'h8 && sel_reg);
            CLS_ALU64: dec.legal = (grp != 4'hf) && (grp != 4'hd) && !(grp == 4'h8 && sel_reg);
            CLS_JUMP: begin
                case (grp)
                    4'h0: begin
                        dec.legal = !sel_reg;
                        dec.cond  = sel_reg ? C_NEVER : C_ALWAYS;
                    end
                    4'h8: begin
                        dec.legal   = !sel_reg;
                        dec.is_call = !sel_reg;
                    end
                    4'h9: begin
                        dec.legal   = !sel_reg;
                        dec.is_exit = !sel_reg;
                    end
                    4'he, 4'hf: dec.legal = 1'b0;
                    default: begin
                        dec.legal = 1'b1;
                        dec.cond  = jump_cond(grp);
                    end
                endcase
            end
            default: dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_cond_eval.sv
// Condition evaluator: tests one condition code on two operands.
// Assumes the operand has already been selected and widened to DATA_W.
module br_cond_eval
    import br_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  cond_t             cond,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              hit
);
    logic eq, ult, slt;

    assign eq  = (a == b);
    assign ult = (a < b);
    assign slt = ($signed(a) < $signed(b));

    // Select the comparison result for the requested condition.
    always_comb begin
        case (cond)
            C_ALWAYS: hit = 1'b1;
            C_EQ:     hit = eq;
            C_NE:     hit = !eq;
            C_GT:     hit = !ult && !eq;
            C_GE:     hit = !ult;
            C_LT:     hit = ult;
            C_LE:     hit = ult || eq;
            C_SGT:    hit = !slt && !eq;
            C_SGE:    hit = !slt;
            C_SLT:    hit = slt;
            C_SLE:    hit = slt || eq;
            C_SET:    hit = |(a & b);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_next_pc.sv
// Next-PC adder: picks the taken target or the sequential successor.
// Assumes PC_W >= OFF_W; sums wrap modulo 2^PC_W.
module br_next_pc #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic             taken,
    input  logic             wide,
    output logic [PC_W-1:0]  next_pc
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] tgt_pc;

    // Widen the offset, then form both candidates.
    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        seq_pc  = pc + (wide ? PC_W'(2) : PC_W'(1));
        tgt_pc  = pc + PC_W'(1) + off_ext;
        next_pc = taken ? tgt_pc : seq_pc;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Branch resolution unit top: decodes the opcode, selects the comparand,
// evaluates the condition and registers taken/next-PC/kind flags.
// Latency is one cycle. Assumes DATA_W >= IMM_W and PC_W >= OFF_W.
module branch_resolve_unit
    import br_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16,
    parameter int PC_W   = 32,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_opcode,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [PC_W-1:0]   in_pc,
    output logic              out_valid,
    output logic              out_taken,
    output logic [PC_W-1:0]   out_next_pc,
    output logic              out_illegal,
    output logic              out_exit,
    output logic              out_call,
    output logic              out_wide
);
    localparam int IMM_EXT = DATA_W - IMM_W;

    dec_t              dec;
    logic [DATA_W-1:0] operand;
    logic              hit;
    logic              taken_c;
    logic [PC_W-1:0]   next_c;

    br_decode #(.OP_W(OP_W)) u_dec (
        .opcode (in_opcode),
        .dec    (dec)
    );

    // Comparand: source register or sign-extended immediate.
    assign operand = dec.use_reg ? in_src : {{IMM_EXT{in_imm[IMM_W-1]}}, in_imm};

    br_cond_eval #(.DATA_W(DATA_W)) u_cmp (
        .cond (dec.cond),
        .a    (in_dst),
        .b    (operand),
        .hit  (hit)
    );

    assign taken_c = dec.legal && hit;

    br_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_npc (
        .pc      (in_pc),
        .off     (in_off),
        .taken   (taken_c),
        .wide    (dec.wide && dec.legal),
        .next_pc (next_c)
    );

    // Output register: flags qualified by valid, next PC held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_illegal <= 1'b0;
            out_exit    <= 1'b0;
            out_call    <= 1'b0;
            out_wide    <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_taken   <= in_valid && taken_c;
            out_illegal <= in_valid && !dec.legal;
            out_exit    <= in_valid && dec.is_exit;
            out_call    <= in_valid && dec.is_call;
            out_wide    <= in_valid && dec.wide && dec.legal;
            if (in_valid) begin
                out_next_pc <= next_c;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_taken || out_illegal || out_exit || out_call || out_wide));

    assert_idle_hold_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_next_pc));

    assert_kinds_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_taken, out_illegal, out_exit, out_call, out_wide}));

    assert_illegal_no_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_taken);

    assert_wide_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 8'h18) |=> (out_wide && out_next_pc == $past(in_pc) + PC_W'(2)));

    assert_ja_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 8'h05) |=> out_taken);

endmodule

// File: tb/sim_branch_resolve_unit.sv
module sim_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_opcode = '0;
    logic [63:0] in_dst = '0;
    logic [63:0] in_src = '0;
    logic [31:0] in_imm = '0;
    logic [15:0] in_off = '0;
    logic [31:0] in_pc = '0;
    logic        out_valid, out_taken, out_illegal, out_exit, out_call, out_wide;
    logic [31:0] out_next_pc;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    branch_resolve_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_off(in_off),
        .in_pc(in_pc), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_illegal(out_illegal), .out_exit(out_exit),
        .out_call(out_call), .out_wide(out_wide)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                         input logic [7:0] op);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%02h actual=%0h expected=%0h", tag, op, act, exp);
        end
    endtask

    function automatic bit legal_op(input logic [7:0] op);
        logic [3:0] n = op[7:4];
        bit r = op[3];
        if (op inside {8'h18, 8'h61, 8'h69, 8'h71, 8'h79, 8'h63, 8'h6b, 8'h73, 8'h7b,
                       8'h85, 8'h95, 8'h05}) return 1;
        case (op[2:0])
            3'b111: return (n != 13) && (n != 15) && !(n == 8 && r);
            3'b100: return (n != 15) && !(n == 8 && r);
            3'b101: return (n >= 1) && (n <= 13) && (n != 8) && (n != 9);
            default: return 0;
        endcase
    endfunction

    function automatic bit cond_true(input logic [7:0] op, input logic [63:0] a,
                                     input logic [63:0] s, input logic [31:0] imm);
        logic [63:0] b = op[3] ? s : {{32{imm[31]}}, imm};
        case (op[7:4])
            4'h0: return 1;
            4'h1: return a == b;
            4'h5: return a != b;
            4'h4: return (a & b) != 0;
            4'h2: return a > b;
            4'h3: return a >= b;
            4'ha: return a < b;
            4'hb: return a <= b;
            4'h6: return $signed(a) > $signed(b);
            4'h7: return $signed(a) >= $signed(b);
            4'hc: return $signed(a) < $signed(b);
            4'hd: return $signed(a) <= $signed(b);
            default: return 0;
        endcase
    endfunction

    function automatic string taken_tag(input logic [7:0] op);
        if (op[2:0] != 3'b101) return "R8";
        case (op[7:4])
            4'h2, 4'h3, 4'ha, 4'hb: return "R3";
            4'h6, 4'h7, 4'hc, 4'hd: return "R4";
            4'h1, 4'h5, 4'h4:       return "R5";
            4'h0:                   return "R7";
            default:                return "R9";
        endcase
    endfunction

    // Drive one instruction and check the registered result.
    task automatic run_one(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                           input logic [31:0] imm, input logic [15:0] off, input logic [31:0] pc,
                           input string tag_over);
        bit lg, br, tk, wd;
        logic [31:0] exp_pc;
        string tt;
        @(negedge clk);
        in_valid = 1; in_opcode = op; in_dst = d; in_src = s;
        in_imm = imm; in_off = off; in_pc = pc;
        @(negedge clk);
        lg = legal_op(op);
        br = lg && op[2:0] == 3'b101 && op[7:4] != 8 && op[7:4] != 9;
        tk = br && cond_true(op, d, s, imm);
        wd = (op == 8'h18);
        if (tk) exp_pc = pc + 32'd1 + {{16{off[15]}}, off};
        else    exp_pc = pc + (wd ? 32'd2 : 32'd1);
        tt = (tag_over != "") ? tag_over : taken_tag(op);
        check({"R2 valid ", tt}, 64'(out_valid), 64'd1, op);
        check({tt, " taken"}, 64'(out_taken), 64'(tk), op);
        check(tk ? "R7 target" : "R8 next", 64'(out_next_pc), 64'(exp_pc), op);
        check("R10 illegal", 64'(out_illegal), 64'(!lg), op);
        check("R9 exit", 64'(out_exit), 64'(op == 8'h95), op);
        check("R9 call", 64'(out_call), 64'(op == 8'h85), op);
        check("R8 wide", 64'(out_wide), 64'(wd), op);
    endtask

    initial begin
        logic [63:0] pd [8];
        logic [63:0] ps [8];
        logic [31:0] pi [8];
        logic [15:0] po [8];
        logic [31:0] pp [8];
        logic [31:0] held;
        pd = '{64'd5, 64'd5, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
               64'd1, 64'hF0, 64'd0};
        ps = '{64'd5, 64'd9, 64'd5, 64'd1, 64'd1, 64'h8000_0000_0000_0000, 64'h0F, 64'd0};
        pi = '{32'd5, 32'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 32'h10, 32'd0};
        po = '{16'd4, 16'hFFFD, 16'h7FFF, 16'h8000, 16'd0, 16'd1, 16'hFFFF, 16'd100};
        pp = '{32'd10, 32'd0, 32'hFFFF_FFFE, 32'd20, 32'd7, 32'h1234, 32'd3, 32'hFFFF_FFFF};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", 64'(out_valid), 64'd0, 8'h00);
        check("R1 taken", 64'(out_taken), 64'd0, 8'h00);
        check("R1 next_pc", 64'(out_next_pc), 64'd0, 8'h00);
        check("R1 flags", 64'({out_illegal, out_exit, out_call, out_wide}), 64'd0, 8'h00);
        rst_n = 1;

        // R6: source selection and immediate sign extension
        run_one(8'h15, 64'd7, 64'd5, 32'd7, 16'd2, 32'd100, "R6");
        run_one(8'h1d, 64'd7, 64'd5, 32'd7, 16'd2, 32'd100, "R6");
        run_one(8'h15, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd100, "R6");
        run_one(8'h25, 64'd3, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd100, "R6");

        // Full opcode sweep over every operand pattern
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 256; o++) begin
                run_one(8'(o), pd[p], ps[p], pi[p], po[p], pp[p], "");
            end
        end

        // R11: idle cycle keeps next PC, clears flags
        run_one(8'h05, 64'd0, 64'd0, 32'd0, 16'd9, 32'd50, "R7");
        held = out_next_pc;
        @(negedge clk);
        in_valid = 0; in_opcode = 8'h05; in_pc = 32'd999;
        @(negedge clk);
        check("R11 valid", 64'(out_valid), 64'd0, 8'h05);
        check("R11 flags", 64'({out_taken, out_illegal, out_exit, out_call, out_wide}), 64'd0, 8'h05);
        check("R11 next_pc", 64'(out_next_pc), 64'(held), 8'h05);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule